// File: doc/BRIEF.md
# Cache Line Maintenance Command Unit

This block carries out one data-cache maintenance command at a time against a single line whose state is modified, exclusive or invalid. The surrounding pipeline presents the command type, the result of the tag lookup (hit and current state), the attributes of the page the address falls in, the privilege level and the cache configuration bits. These are all sampled in one cycle. The block then decides what the command does to the line. It raises a line-fill, a line-zero or a write-back request, an address-only broadcast request, or one of three exception flags.

Broadcast and write-back requests are held until the bus side acknowledges them. The broadcast always goes first. When every requested transfer has been acknowledged, the block gives a single completion pulse. The new line state, the fill or zero request and any exception flag are valid only during that pulse, so the tag array is updated only after the bus work is done. Address translation and bus timing belong to neighbouring blocks.

Top module: `cmo_unit`

## Requirements
- R1: Touch (op 3'd0) and touch-for-store (op 3'd1) behave identically. On a lookup miss, with the cache enabled, unlocked, translation hit, access permitted and the page cacheable, the completion pulse carries `fill_req` and a state update to exclusive (2'b01). In every other case the command has no effect. A lookup counts as a hit only when `lk_hit` is set and the state is exclusive (2'b01) or modified (2'b10).
- R2: A touch command has no effect while the cache is disabled or locked.
- R3: Zero (op 3'd2) on a hit, or on a miss to a cacheable page, gives `zero_req` and a state update to modified (2'b10). This also applies when the cache is locked.
- R4: Zero on a coherence-required page raises `bcast_req`, and the completion pulse with the state update comes only after `bcast_ack`.
- R5: Zero raises `exc_align`, with no state update, no request and no broadcast, when the cache is disabled or the page is inhibited, write-through or not cacheable.
- R6: Store-back (op 3'd3) on a modified hit raises `wb_req` and updates the line to exclusive. On an exclusive hit or a miss there is no write-back and no update.
- R7: Flush (op 3'd4) on a modified hit raises `wb_req` and updates the line to invalid (2'b00). On an exclusive hit it updates the line to invalid without a write-back. On a miss it has no effect.
- R8: Invalidate (op 3'd5) at supervisor level updates a hit line to invalid, even a modified one, with no write-back. At user level it raises `exc_priv` with no update and no broadcast.
- R9: Store-back, flush and invalidate act the same whether the cache is disabled or locked. They raise `bcast_req` if and only if the broadcast-enable bit is set.
- R10: A protection violation (`pg_prot_ok` low) on zero, store-back, flush or invalidate raises `exc_dsi` only, with no update and no request. At most one exception flag is ever set, with privilege ahead of protection ahead of alignment.
- R11: Each request is held until acknowledged. Broadcast precedes write-back, and the two are never high together. Exactly one `done` pulse follows the last acknowledgement, one cycle after acceptance when nothing is requested. `cmd_ready` is low from acceptance to completion. Outside the pulse, all result outputs are low.
- R12: Reserved ops (3'd6, 3'd7) complete with one `done` pulse and no effect.
- R13: `req_addr` is the command address with its line-offset bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Command address |
| lk_hit | input | 1 | Tag lookup hit |
| lk_state | input | 2 | Current line state |
| pg_coh | input | 1 | Page requires coherence |
| pg_inhib | input | 1 | Page is caching-inhibited |
| pg_wthru | input | 1 | Page is write-through |
| pg_cacheable | input | 1 | Page is cacheable |
| pg_xlat_hit | input | 1 | Translation found |
| pg_prot_ok | input | 1 | Access permitted |
| cfg_sup | input | 1 | Supervisor level |
| cfg_en | input | 1 | Cache enabled |
| cfg_lock | input | 1 | Cache locked |
| cfg_bcast_en | input | 1 | External broadcast of maintenance commands enabled |
| wb_req | output | 1 | Write-back request |
| wb_ack | input | 1 | Write-back done |
| bcast_req | output | 1 | Address-only broadcast request |
| bcast_ack | input | 1 | Broadcast done |
| req_addr | output | ADDR_W | Line address for requests |
| done | output | 1 | Command complete pulse |
| upd_vld | output | 1 | Write new line state |
| upd_state | output | 2 | New line state |
| fill_req | output | 1 | Fetch line into cache |
| zero_req | output | 1 | Clear line (allocating on a miss) |
| exc_align | output | 1 | Alignment exception |
| exc_dsi | output | 1 | Data storage exception |
| exc_priv | output | 1 | Privilege exception |

## Verification
The command decision is stored once at acceptance. A wrong stored decision therefore shows on the single completion pulse as a wrong `upd_state`, a missing or extra `fill_req`/`zero_req`, or a wrong exception flag. That pulse comes one cycle after acceptance, or one cycle after the last acknowledgement. A sequencer that reaches the wrong state shows at once as a request raised out of order, a request dropped before its acknowledgement, two pulses, or a `cmd_ready` that stays low after completion. The bench varies acknowledgement latency so that the holding and ordering of requests are both seen.

// File: rtl/cmo_pkg.sv
// Shared encodings and bundles for the cache line maintenance unit.
// Assumes op and line-state codes are fixed by the surrounding pipeline.
package cmo_pkg;

    typedef enum logic [2:0] {
        OP_TOUCH    = 3'd0,
        OP_TOUCH_ST = 3'd1,
        OP_ZERO     = 3'd2,
        OP_STORE    = 3'd3,
        OP_FLUSH    = 3'd4,
        OP_INVAL    = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } cmo_op_e;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_EXC = 2'b01,
        LS_MOD = 2'b10,
        LS_RSV = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BCAST = 2'd1,
        SQ_WB    = 2'd2,
        SQ_DONE  = 2'd3
    } seq_st_e;

    // Page attributes sampled with the command.
    typedef struct packed {
        logic coh;
        logic inhib;
        logic wthru;
        logic cacheable;
        logic xlat_hit;
        logic prot_ok;
    } page_attr_t;

    // Configuration and privilege sampled with the command.
    typedef struct packed {
        logic en;
        logic lock;
        logic bcast_en;
        logic sup;
    } cache_ctl_t;

    // Decoded command classes plus lookup summary.
    typedef struct packed {
        logic touch;
        logic zero;
        logic store;
        logic flush;
        logic inval;
        logic resident;
        logic dirty;
    } cmd_class_t;

    // Everything a command will do, decided at acceptance.
    typedef struct packed {
        logic     bcast;
        logic     wb;
        logic     upd;
        line_st_e nst;
        logic     fill;
        logic     zero;
        logic     exc_align;
        logic     exc_dsi;
        logic     exc_priv;
    } cmo_plan_t;

endpackage

// File: rtl/cmo_classify.sv
// Decodes the command code into one-hot classes and summarizes the
// tag lookup. Assumes a lookup with state invalid or reserved is a miss.
module cmo_classify
    import cmo_pkg::*;
(
    input  logic [2:0] op,
    input  logic       hit,
    input  logic [1:0] state,
    output cmd_class_t cls
);

    line_st_e st;

    // Cast raw state to the enum and classify the op.
    always_comb begin
        st           = line_st_e'(state);
        cls          = '0;
        cls.resident = hit && (st == LS_EXC || st == LS_MOD);
        cls.dirty    = hit && (st == LS_MOD);
        unique case (cmo_op_e'(op))
            OP_TOUCH, OP_TOUCH_ST: cls.touch = 1'b1;
            OP_ZERO:               cls.zero  = 1'b1;
            OP_STORE:              cls.store = 1'b1;
            OP_FLUSH:              cls.flush = 1'b1;
            OP_INVAL:              cls.inval = 1'b1;
            default:               ;
        endcase
    end

endmodule

// File: rtl/cmo_rules.sv
// Per-command rules: state change, requests, broadcast gating and
// exception selection. Purely combinational. Assumes a touch never
// allocates into a locked cache, and exception priority is
// privilege, then protection, then alignment.
module cmo_rules
    import cmo_pkg::*;
(
    input  cmd_class_t cls,
    input  page_attr_t pg,
    input  cache_ctl_t ctl,
    output cmo_plan_t  plan
);

    logic touch_ok;
    logic zero_bad;

    // Qualifiers shared by the touch and zero rules.
    always_comb begin
        touch_ok = ctl.en && !ctl.lock && pg.xlat_hit && pg.prot_ok
                   && pg.cacheable && !cls.resident;
        zero_bad = !ctl.en || pg.inhib || pg.wthru || !pg.cacheable;
    end

    // Build the action plan for the current command.
    always_comb begin
        plan     = '0;
        plan.nst = LS_INV;
        if (cls.touch) begin
            if (touch_ok) begin
                plan.fill = 1'b1;
                plan.upd  = 1'b1;
                plan.nst  = LS_EXC;
            end
        end else if (cls.zero) begin
            if (!pg.prot_ok) begin
                plan.exc_dsi = 1'b1;
            end else if (zero_bad) begin
                plan.exc_align = 1'b1;
            end else begin
                plan.zero  = 1'b1;
                plan.upd   = 1'b1;
                plan.nst   = LS_MOD;
                plan.bcast = pg.coh;
            end
        end else if (cls.store) begin
            if (!pg.prot_ok) begin
                plan.exc_dsi = 1'b1;
            end else begin
                plan.bcast = ctl.bcast_en;
                if (cls.dirty) begin
                    plan.wb  = 1'b1;
                    plan.upd = 1'b1;
                    plan.nst = LS_EXC;
                end
            end
        end else if (cls.flush) begin
            if (!pg.prot_ok) begin
                plan.exc_dsi = 1'b1;
            end else begin
                plan.bcast = ctl.bcast_en;
                plan.wb    = cls.dirty;
                plan.upd   = cls.resident;
                plan.nst   = LS_INV;
            end
        end else if (cls.inval) begin
            if (!ctl.sup) begin
                plan.exc_priv = 1'b1;
            end else if (!pg.prot_ok) begin
                plan.exc_dsi = 1'b1;
            end else begin
                plan.bcast = ctl.bcast_en;
                plan.upd   = cls.resident;
                plan.nst   = LS_INV;
            end
        end
    end

endmodule

// File: rtl/cmo_seq.sv
// Command sequencer: captures the plan and line address on acceptance,
// runs the broadcast then the write-back handshake, each held until
// acknowledged, and ends with a one-cycle completion state.
// Assumes acks are only meaningful while the matching request is high.
module cmo_seq
    import cmo_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  cmo_plan_t         plan_in,
    input  logic              bcast_ack,
    input  logic              wb_ack,
    output logic              cmd_ready,
    output logic              bcast_req,
    output logic              wb_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output cmo_plan_t         plan_q
);

    seq_st_e           st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    // First stage a fresh plan needs.
    function automatic seq_st_e first_stage(input cmo_plan_t p);
        if (p.bcast)   return SQ_BCAST;
        else if (p.wb) return SQ_WB;
        else           return SQ_DONE;
    endfunction

    assign accept = cmd_valid && (st_q == SQ_IDLE);

    // Next-state selection for the handshake sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:  if (cmd_valid) st_d = first_stage(plan_in);
            SQ_BCAST: if (bcast_ack) st_d = plan_q.wb ? SQ_WB : SQ_DONE;
            SQ_WB:    if (wb_ack)    st_d = SQ_DONE;
            SQ_DONE:  st_d = SQ_IDLE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    // State, plan and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            plan_q <= '0;
            addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                plan_q               <= plan_in;
                addr_q               <= cmd_addr;
                addr_q[OFS_W-1:0]    <= '0;
            end
        end
    end

    assign cmd_ready = (st_q == SQ_IDLE);
    assign bcast_req = (st_q == SQ_BCAST);
    assign wb_req    = (st_q == SQ_WB);
    assign done      = (st_q == SQ_DONE);
    assign req_addr  = addr_q;

endmodule

// File: rtl/cmo_unit.sv
// Cache line maintenance command unit top. Classifies the command,
// applies the per-command rules, and sequences handshakes; results are
// presented only during the completion pulse. Assumes line size
// LINE_BYTES is a power of two and at most 2**(ADDR_W-1).
module cmo_unit
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              lk_hit,
    input  logic [1:0]        lk_state,
    input  logic              pg_coh,
    input  logic              pg_inhib,
    input  logic              pg_wthru,
    input  logic              pg_cacheable,
    input  logic              pg_xlat_hit,
    input  logic              pg_prot_ok,
    input  logic              cfg_sup,
    input  logic              cfg_en,
    input  logic              cfg_lock,
    input  logic              cfg_bcast_en,
    output logic              wb_req,
    input  logic              wb_ack,
    output logic              bcast_req,
    input  logic              bcast_ack,
    output logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic              upd_vld,
    output logic [1:0]        upd_state,
    output logic              fill_req,
    output logic              zero_req,
    output logic              exc_align,
    output logic              exc_dsi,
    output logic              exc_priv
);

    localparam int OFS_W = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 1;

    cmd_class_t cls;
    page_attr_t pg;
    cache_ctl_t ctl;
    cmo_plan_t  plan_d, plan_q;

    // Bundle the sampled attributes and configuration.
    always_comb begin
        pg.coh       = pg_coh;
        pg.inhib     = pg_inhib;
        pg.wthru     = pg_wthru;
        pg.cacheable = pg_cacheable;
        pg.xlat_hit  = pg_xlat_hit;
        pg.prot_ok   = pg_prot_ok;
        ctl.en       = cfg_en;
        ctl.lock     = cfg_lock;
        ctl.bcast_en = cfg_bcast_en;
        ctl.sup      = cfg_sup;
    end

    cmo_classify u_cls (
        .op    (cmd_op),
        .hit   (lk_hit),
        .state (lk_state),
        .cls   (cls)
    );

    cmo_rules u_rules (
        .cls  (cls),
        .pg   (pg),
        .ctl  (ctl),
        .plan (plan_d)
    );

    cmo_seq #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .plan_in   (plan_d),
        .bcast_ack (bcast_ack),
        .wb_ack    (wb_ack),
        .cmd_ready (cmd_ready),
        .bcast_req (bcast_req),
        .wb_req    (wb_req),
        .req_addr  (req_addr),
        .done      (done),
        .plan_q    (plan_q)
    );

    // Results are visible only during the completion pulse.
    always_comb begin
        upd_vld   = done && plan_q.upd;
        upd_state = (done && plan_q.upd) ? plan_q.nst : LS_INV;
        fill_req  = done && plan_q.fill;
        zero_req  = done && plan_q.zero;
        exc_align = done && plan_q.exc_align;
        exc_dsi   = done && plan_q.exc_dsi;
        exc_priv  = done && plan_q.exc_priv;
    end

endmodule

// File: rtl/cmo_unit_chk.sv
// Port-level protocol and result checks for cmo_unit, bound to every
// instance. Assumes synchronous active-low reset.
module cmo_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       wb_req,
    input logic       wb_ack,
    input logic       bcast_req,
    input logic       bcast_ack,
    input logic       done,
    input logic       upd_vld,
    input logic [1:0] upd_state,
    input logic       fill_req,
    input logic       zero_req,
    input logic       exc_align,
    input logic       exc_dsi,
    input logic       exc_priv
);

    logic any_exc;
    assign any_exc = exc_align || exc_dsi || exc_priv;

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && bcast_req)); // R11
    AST_BCAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_req && !bcast_ack |=> bcast_req); // R11
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req); // R11
    AST_WB_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && wb_ack |=> done); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req || bcast_req || done) |-> !cmd_ready); // R11
    AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(upd_vld || fill_req || zero_req || any_exc)); // R11
    AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_align, exc_dsi, exc_priv})); // R10
    AST_EXC_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        any_exc |-> !(upd_vld || fill_req || zero_req)); // R10
    AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> upd_vld && upd_state == 2'b01); // R1
    AST_ZERO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |-> upd_vld && upd_state == 2'b10); // R3

endmodule

bind cmo_unit cmo_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .wb_req    (wb_req),
    .wb_ack    (wb_ack),
    .bcast_req (bcast_req),
    .bcast_ack (bcast_ack),
    .done      (done),
    .upd_vld   (upd_vld),
    .upd_state (upd_state),
    .fill_req  (fill_req),
    .zero_req  (zero_req),
    .exc_align (exc_align),
    .exc_dsi   (exc_dsi),
    .exc_priv  (exc_priv)
);

// File: tb/cmo_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for cmo_unit: one task per scenario, each checking
// its own results at the ports.
module cmo_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          lk_hit, pg_coh, pg_inhib, pg_wthru, pg_cacheable;
    logic [1:0]    lk_state;
    logic          pg_xlat_hit, pg_prot_ok, cfg_sup, cfg_en, cfg_lock, cfg_bcast_en;
    logic          wb_req, bcast_req, done, upd_vld, fill_req, zero_req;
    logic          wb_ack = 1'b0, bcast_ack = 1'b0;
    logic [AW-1:0] req_addr;
    logic [1:0]    upd_state;
    logic          exc_align, exc_dsi, exc_priv;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // Per-command observations.
    int r_done, r_bc, r_wb, r_first_wb, r_last_bc, r_rdy_bad, r_addr_bad;
    int r_upd, r_st, r_fill, r_zero, r_exc;
    int g_bc_lat = 0, g_wb_lat = 0;

    always #4 clk = ~clk;

    cmo_unit dut_i (.*);

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic defaults();
        lk_hit = 0; lk_state = 2'b00; pg_coh = 0; pg_inhib = 0; pg_wthru = 0;
        pg_cacheable = 1; pg_xlat_hit = 1; pg_prot_ok = 1; cfg_sup = 1;
        cfg_en = 1; cfg_lock = 0; cfg_bcast_en = 0; g_bc_lat = 0; g_wb_lat = 0;
    endtask

    // Issue one command, serve acks with the set latencies, observe.
    task automatic issue(logic [2:0] op);
        int done_c = -1;
        r_done = 0; r_bc = 0; r_wb = 0; r_first_wb = -1; r_last_bc = -1;
        r_rdy_bad = 0; r_addr_bad = 0;
        r_upd = 0; r_st = 0; r_fill = 0; r_zero = 0; r_exc = 0;
        @(negedge clk);
        cmd_op = op; cmd_valid = 1'b1;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            cmd_valid = 1'b0; bcast_ack = 1'b0; wb_ack = 1'b0;
            if (bcast_req) begin
                r_bc++; r_last_bc = c;
                if (cmd_ready) r_rdy_bad++;
                if (req_addr != {cmd_addr[AW-1:5], 5'b0}) r_addr_bad++;
                if (r_bc == g_bc_lat + 1) bcast_ack = 1'b1;
            end
            if (wb_req) begin
                r_wb++;
                if (r_first_wb < 0) r_first_wb = c;
                if (cmd_ready) r_rdy_bad++;
                if (req_addr != {cmd_addr[AW-1:5], 5'b0}) r_addr_bad++;
                if (r_wb == g_wb_lat + 1) wb_ack = 1'b1;
            end
            if (done) begin
                r_done++; done_c = c;
                if (cmd_ready) r_rdy_bad++;
                r_upd = upd_vld; r_st = upd_state; r_fill = fill_req;
                r_zero = zero_req; r_exc = {exc_align, exc_dsi, exc_priv};
            end
            if (done_c >= 0 && c >= done_c + 2) break;
        end
    endtask

    // Compare one command's observations; exc bits are {align,dsi,priv}.
    task automatic expect_res(string tag, bit e_upd, logic [1:0] e_st, bit e_fill,
                              bit e_zero, logic [2:0] e_exc, bit e_bc, bit e_wb);
        check(tag, "done pulses", r_done, 1);
        check(tag, "upd_vld", r_upd, int'(e_upd));
        if (e_upd) check(tag, "upd_state", r_st, int'(e_st));
        check(tag, "fill_req", r_fill, int'(e_fill));
        check(tag, "zero_req", r_zero, int'(e_zero));
        check(tag, "exceptions", r_exc, int'(e_exc));
        check(tag, "bcast cycles", r_bc, e_bc ? g_bc_lat + 1 : 0);
        check(tag, "wb cycles", r_wb, e_wb ? g_wb_lat + 1 : 0);
        check(tag, "ready while busy", r_rdy_bad, 0);
        if (e_bc && e_wb) check(tag, "bcast before wb", int'(r_last_bc < r_first_wb), 1);
    endtask

    task automatic t_reset();
        check("R11", "reset ready", cmd_ready, 1);
        check("R11", "reset done", done, 0);
        check("R11", "reset reqs", {wb_req, bcast_req}, 0);
    endtask

    task automatic t_touch();
        defaults(); issue(3'd0); expect_res("R1", 1, 2'b01, 1, 0, 3'b000, 0, 0);
        defaults(); issue(3'd1); expect_res("R1", 1, 2'b01, 1, 0, 3'b000, 0, 0);
        defaults(); lk_hit = 1; lk_state = 2'b01; issue(3'd0);
        expect_res("R1", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); lk_hit = 1; lk_state = 2'b00; issue(3'd1);
        expect_res("R1", 1, 2'b01, 1, 0, 3'b000, 0, 0);
        defaults(); pg_cacheable = 0; issue(3'd0); expect_res("R1", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); pg_xlat_hit = 0; issue(3'd1); expect_res("R1", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); pg_prot_ok = 0; issue(3'd0); expect_res("R1", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); cfg_en = 0; issue(3'd0); expect_res("R2", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); cfg_lock = 1; issue(3'd1); expect_res("R2", 0, 0, 0, 0, 3'b000, 0, 0);
    endtask

    task automatic t_zero();
        defaults(); lk_hit = 1; lk_state = 2'b01; issue(3'd2);
        expect_res("R3", 1, 2'b10, 0, 1, 3'b000, 0, 0);
        defaults(); cfg_lock = 1; issue(3'd2); expect_res("R3", 1, 2'b10, 0, 1, 3'b000, 0, 0);
        defaults(); pg_coh = 1; g_bc_lat = 3; cmd_addr = 32'h1234_567F; issue(3'd2);
        expect_res("R4", 1, 2'b10, 0, 1, 3'b000, 1, 0);
        check("R13", "req_addr line aligned", r_addr_bad, 0);
        defaults(); cfg_en = 0; pg_coh = 1; issue(3'd2); expect_res("R5", 0, 0, 0, 0, 3'b100, 0, 0);
        defaults(); pg_inhib = 1; issue(3'd2); expect_res("R5", 0, 0, 0, 0, 3'b100, 0, 0);
        defaults(); pg_wthru = 1; lk_hit = 1; lk_state = 2'b10; issue(3'd2);
        expect_res("R5", 0, 0, 0, 0, 3'b100, 0, 0);
        defaults(); pg_cacheable = 0; issue(3'd2); expect_res("R5", 0, 0, 0, 0, 3'b100, 0, 0);
    endtask

    task automatic t_store();
        defaults(); lk_hit = 1; lk_state = 2'b10; issue(3'd3);
        expect_res("R6", 1, 2'b01, 0, 0, 3'b000, 0, 1);
        defaults(); lk_hit = 1; lk_state = 2'b01; issue(3'd3);
        expect_res("R6", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); issue(3'd3); expect_res("R6", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); cfg_en = 0; cfg_lock = 1; lk_hit = 1; lk_state = 2'b10; issue(3'd3);
        expect_res("R9", 1, 2'b01, 0, 0, 3'b000, 0, 1);
    endtask

    task automatic t_flush();
        defaults(); lk_hit = 1; lk_state = 2'b10; issue(3'd4);
        expect_res("R7", 1, 2'b00, 0, 0, 3'b000, 0, 1);
        defaults(); lk_hit = 1; lk_state = 2'b01; issue(3'd4);
        expect_res("R7", 1, 2'b00, 0, 0, 3'b000, 0, 0);
        defaults(); issue(3'd4); expect_res("R7", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); cfg_bcast_en = 1; cfg_lock = 1; g_bc_lat = 2; g_wb_lat = 4;
        cmd_addr = 32'hABCD_0013; lk_hit = 1; lk_state = 2'b10; issue(3'd4);
        expect_res("R9", 1, 2'b00, 0, 0, 3'b000, 1, 1);
        check("R13", "req_addr line aligned", r_addr_bad, 0);
    endtask

    task automatic t_inval();
        defaults(); lk_hit = 1; lk_state = 2'b10; issue(3'd5);
        expect_res("R8", 1, 2'b00, 0, 0, 3'b000, 0, 0);
        defaults(); cfg_sup = 0; cfg_bcast_en = 1; lk_hit = 1; lk_state = 2'b10; issue(3'd5);
        expect_res("R8", 0, 0, 0, 0, 3'b001, 0, 0);
        defaults(); cfg_en = 0; cfg_bcast_en = 1; g_bc_lat = 1; lk_hit = 1; lk_state = 2'b01;
        issue(3'd5); expect_res("R9", 1, 2'b00, 0, 0, 3'b000, 1, 0);
    endtask

    task automatic t_protect();
        defaults(); pg_prot_ok = 0; pg_coh = 1; issue(3'd2); expect_res("R10", 0, 0, 0, 0, 3'b010, 0, 0);
        defaults(); pg_prot_ok = 0; cfg_en = 0; issue(3'd2); expect_res("R10", 0, 0, 0, 0, 3'b010, 0, 0);
        defaults(); pg_prot_ok = 0; lk_hit = 1; lk_state = 2'b10; issue(3'd3);
        expect_res("R10", 0, 0, 0, 0, 3'b010, 0, 0);
        defaults(); pg_prot_ok = 0; cfg_bcast_en = 1; lk_hit = 1; lk_state = 2'b10; issue(3'd4);
        expect_res("R10", 0, 0, 0, 0, 3'b010, 0, 0);
        defaults(); pg_prot_ok = 0; cfg_sup = 0; issue(3'd5); expect_res("R10", 0, 0, 0, 0, 3'b001, 0, 0);
    endtask

    task automatic t_reserved();
        defaults(); cfg_bcast_en = 1; lk_hit = 1; lk_state = 2'b10; issue(3'd6);
        expect_res("R12", 0, 0, 0, 0, 3'b000, 0, 0);
        defaults(); pg_prot_ok = 0; issue(3'd7); expect_res("R12", 0, 0, 0, 0, 3'b000, 0, 0);
    endtask

    task automatic t_handshake();
        defaults(); g_wb_lat = 6; lk_hit = 1; lk_state = 2'b10; issue(3'd3);
        expect_res("R11", 1, 2'b01, 0, 0, 3'b000, 0, 1);
        defaults(); cfg_bcast_en = 1; g_bc_lat = 5; g_wb_lat = 0; lk_hit = 1; lk_state = 2'b10;
        issue(3'd3); expect_res("R11", 1, 2'b01, 0, 0, 3'b000, 1, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        defaults();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_touch();
        t_zero();
        t_store();
        t_flush();
        t_inval();
        t_protect();
        t_reserved();
        t_handshake();
        finish_run();
    end

endmodule